// File: doc/BRIEF.md
# General-Purpose Parallel IO Port Controller

This block controls a port of 32 general-purpose pins through a small word-addressed register bus. Every pin can belong to the controller or be handed to one of two peripheral functions. A controller-owned pin can drive a latched output level or act as an input. Open-drain output, a pull-up and an input glitch filter can each be switched on per pin. Each per-pin setting has one write register that turns selected bits on, one that turns them off, and a status register that reads the setting back. A zero bit in either write leaves that pin alone.

On the input side, each pad passes through a two-flop synchronizer and an optional filter. Any edge of the resulting level latches a change bit. Reading the change register returns the latched bits and clears them in the same access. A single interrupt line is high while any latched change bit is also enabled in the interrupt mask. The pads are modelled as separate input, output, output-enable and pull-up signals.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every pin is a controller-owned input with its pull-up on. Filters, open-drain mode and interrupt enables are off, the function select reads 0, output data is 0 and the change register reads 0.
- R2: Register word offsets, in enable/disable/status order: ownership 0/1/2, output enable 3/4/5, open-drain 6/7/8, pull-up 9/10/11, glitch filter 12/13/14, interrupt mask 15/16/17. A write to an enable offset sets the ones of the write data, a write to a disable offset clears them, and zero bits leave the setting unchanged. Bit i always belongs to pin i.
- R3: Output data: a write to offset 21 drives the chosen bits to 1, a write to offset 22 drives them to 0, and offset 23 reads the latched data back.
- R4: Offset 24 returns the synchronized pad levels of all pins, whatever their direction, two clocks after the pad changes. Read data appears one cycle after the read strobe.
- R5: For a controller-owned push-pull pin, pad_oe follows the output-enable setting and pad_out follows the output data.
- R6: For an open-drain pin, pad_out is 0. An output data of 1 releases the pad (pad_oe 0), and an output data of 0 drives it low when output enable is set.
- R7: Offset 18 selects function A and offset 19 selects function B for the chosen bits, and offset 20 reads back the selection with 1 meaning B. A pin that is not controller-owned takes pad_out and pad_oe from the selected function.
- R8: pad_pu equals the pull-up setting of every pin.
- R9: Any rising or falling edge of a pin's filtered level latches its change bit, whether or not the pin is masked. A read of offset 25 returns the latched bits and clears them.
- R10: irq is high exactly when some latched change bit has its interrupt mask bit set.
- R11: With the filter on, a new level is accepted only after it has been seen for two consecutive clocks, so a one-clock pulse latches no change. Without the filter, the same pulse latches one.
- R12: A change that arrives in the same cycle as a clearing read of offset 25 stays latched. That read returns the older value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word offset |
| bus_wdata | input | N | Write data |
| bus_rdata | output | N | Read data, valid one cycle after a read strobe |
| pad_in | input | N | Pad levels |
| pad_out | output | N | Pad drive level |
| pad_oe | output | N | Pad drive enable |
| pad_pu | output | N | Pad pull-up enable |
| pfa_out | input | N | Function A output level |
| pfa_oe | input | N | Function A output enable |
| pfb_out | input | N | Function B output level |
| pfb_oe | input | N | Function B output enable |
| pf_in | output | N | Filtered pin levels for the peripherals |
| irq | output | 1 | Change interrupt |

## Verification
The set/clear scheme is tried with overlapping, disjoint and all-ones masks. These patterns separate a true bit-wise set or clear from a plain overwrite, and show whether zero bits are really ignored. The change logic is driven with rising and falling edges on a masked pin and an unmasked pin, and with a one-clock pulse with and without the filter. These patterns show that latching does not depend on the mask, that irq does, and that the filter rejects short pulses. A change is timed to land on the same edge as a clearing read, to show that the new change takes priority over the clear.

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int N  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  input  logic [N-1:0]  pad_in,
  output logic [N-1:0]  pad_out,
  output logic [N-1:0]  pad_oe,
  output logic [N-1:0]  pad_pu,
  input  logic [N-1:0]  pfa_out,
  input  logic [N-1:0]  pfa_oe,
  input  logic [N-1:0]  pfb_out,
  input  logic [N-1:0]  pfb_oe,
  output logic [N-1:0]  pf_in,
  output logic          irq
);
  localparam logic [AW-1:0] OWN_EN = AW'(0),  OWN_DIS = AW'(1),  OWN_ST = AW'(2);
  localparam logic [AW-1:0] OE_EN  = AW'(3),  OE_DIS  = AW'(4),  OE_ST  = AW'(5);
  localparam logic [AW-1:0] OD_EN  = AW'(6),  OD_DIS  = AW'(7),  OD_ST  = AW'(8);
  localparam logic [AW-1:0] PU_EN  = AW'(9),  PU_DIS  = AW'(10), PU_ST  = AW'(11);
  localparam logic [AW-1:0] FL_EN  = AW'(12), FL_DIS  = AW'(13), FL_ST  = AW'(14);
  localparam logic [AW-1:0] IE_EN  = AW'(15), IE_DIS  = AW'(16), IE_ST  = AW'(17);
  localparam logic [AW-1:0] SEL_A  = AW'(18), SEL_B   = AW'(19), SEL_ST = AW'(20);
  localparam logic [AW-1:0] D_SET  = AW'(21), D_CLR   = AW'(22), D_ST   = AW'(23);
  localparam logic [AW-1:0] PIN_ST = AW'(24), CHG_ST  = AW'(25);

  logic [N-1:0] own_q, oe_q, od_q, pu_q, flt_q, ie_q, sel_q, dout_q;
  logic [N-1:0] s1, s2, s3, lvl, lvl_q, isr_q, chg, eq;
  logic [N-1:0] rd_mux, src_out, src_oe;
  logic         wr_en, rd_en, rd_chg;

  assign wr_en  = bus_sel & bus_wr;
  assign rd_en  = bus_sel & ~bus_wr;
  assign rd_chg = rd_en && (bus_addr == CHG_ST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= '1;
      oe_q   <= '0;
      od_q   <= '0;
      pu_q   <= '1;
      flt_q  <= '0;
      ie_q   <= '0;
      sel_q  <= '0;
      dout_q <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        OWN_EN:  own_q  <= own_q  |  bus_wdata;
        OWN_DIS: own_q  <= own_q  & ~bus_wdata;
        OE_EN:   oe_q   <= oe_q   |  bus_wdata;
        OE_DIS:  oe_q   <= oe_q   & ~bus_wdata;
        OD_EN:   od_q   <= od_q   |  bus_wdata;
        OD_DIS:  od_q   <= od_q   & ~bus_wdata;
        PU_EN:   pu_q   <= pu_q   |  bus_wdata;
        PU_DIS:  pu_q   <= pu_q   & ~bus_wdata;
        FL_EN:   flt_q  <= flt_q  |  bus_wdata;
        FL_DIS:  flt_q  <= flt_q  & ~bus_wdata;
        IE_EN:   ie_q   <= ie_q   |  bus_wdata;
        IE_DIS:  ie_q   <= ie_q   & ~bus_wdata;
        SEL_A:   sel_q  <= sel_q  & ~bus_wdata;
        SEL_B:   sel_q  <= sel_q  |  bus_wdata;
        D_SET:   dout_q <= dout_q |  bus_wdata;
        D_CLR:   dout_q <= dout_q & ~bus_wdata;
        default: ;
      endcase
    end
  end

  assign eq = ~(s2 ^ s3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= '0;
      s2    <= '0;
      s3    <= '0;
      lvl   <= '0;
      lvl_q <= '0;
      isr_q <= '0;
    end else begin
      s1    <= pad_in;
      s2    <= s1;
      s3    <= s2;
      lvl   <= (~flt_q & s2) | (flt_q & ((eq & s2) | (~eq & lvl)));
      lvl_q <= lvl;
      isr_q <= (rd_chg ? '0 : isr_q) | chg;
    end
  end

  assign chg   = lvl ^ lvl_q;
  assign pf_in = lvl;
  assign irq   = |(isr_q & ie_q);

  always_comb begin
    case (bus_addr)
      OWN_ST:  rd_mux = own_q;
      OE_ST:   rd_mux = oe_q;
      OD_ST:   rd_mux = od_q;
      PU_ST:   rd_mux = pu_q;
      FL_ST:   rd_mux = flt_q;
      IE_ST:   rd_mux = ie_q;
      SEL_ST:  rd_mux = sel_q;
      D_ST:    rd_mux = dout_q;
      PIN_ST:  rd_mux = s2;
      CHG_ST:  rd_mux = isr_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end

  assign src_out = (own_q & dout_q) | (~own_q & ((sel_q & pfb_out) | (~sel_q & pfa_out)));
  assign src_oe  = (own_q & oe_q)   | (~own_q & ((sel_q & pfb_oe)  | (~sel_q & pfa_oe)));
  assign pad_out = src_out & ~od_q;
  assign pad_oe  = src_oe & ~(od_q & src_out);
  assign pad_pu  = pu_q;
endmodule

module gpio_port_ctrl_chk #(
  parameter int N  = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [N-1:0]  bus_wdata,
  input logic [N-1:0]  own_q,
  input logic [N-1:0]  oe_q,
  input logic [N-1:0]  od_q,
  input logic [N-1:0]  dout_q,
  input logic [N-1:0]  ie_q,
  input logic [N-1:0]  isr_q,
  input logic [N-1:0]  chg,
  input logic [N-1:0]  pad_oe,
  input logic          irq
);
  assert_oe_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == AW'(3)) |=> ((oe_q & $past(bus_wdata)) == $past(bus_wdata)));
  assert_oe_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == AW'(4)) |=> ((oe_q & $past(bus_wdata)) == '0));
  assert_od_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((own_q & od_q & dout_q & pad_oe) == '0));
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == AW'(25) && chg == '0) |=> (isr_q == '0));
  assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie_q != '0));
  assert_change_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |=> ((isr_q & $past(chg)) == $past(chg)));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .own_q(own_q), .oe_q(oe_q),
  .od_q(od_q), .dout_q(dout_q), .ie_q(ie_q), .isr_q(isr_q), .chg(chg),
  .pad_oe(pad_oe), .irq(irq)
);

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
  localparam int N = 32, AW = 5;
  localparam logic [4:0] A_OWN_DIS = 1, A_OWN_ST = 2, A_OE_EN = 3, A_OE_DIS = 4,
    A_OE_ST = 5, A_OD_EN = 6, A_OD_ST = 8, A_PU_DIS = 10, A_PU_ST = 11,
    A_FL_EN = 12, A_FL_DIS = 13, A_FL_ST = 14, A_IE_EN = 15, A_IE_ST = 17,
    A_SEL_B = 19, A_SEL_ST = 20, A_DSET = 21, A_DCLR = 22, A_DST = 23,
    A_PIN = 24, A_CHG = 25;
  localparam int NV = 24;
  // {write, offset, data}: reads compare against data
  localparam logic [37:0] VECS [0:NV-1] = '{
    {1'b0, A_OWN_ST, 32'hFFFF_FFFF},   // R1
    {1'b0, A_OE_ST,  32'h0},           // R1
    {1'b0, A_OD_ST,  32'h0},           // R1
    {1'b0, A_PU_ST,  32'hFFFF_FFFF},   // R1
    {1'b0, A_FL_ST,  32'h0},           // R1
    {1'b0, A_IE_ST,  32'h0},           // R1
    {1'b0, A_SEL_ST, 32'h0},           // R1
    {1'b0, A_DST,    32'h0},           // R1
    {1'b0, A_CHG,    32'h0},           // R1
    {1'b1, A_OE_EN,  32'h0000_F0F0},   // R2
    {1'b1, A_OE_EN,  32'h0F00_0000},
    {1'b0, A_OE_ST,  32'h0F00_F0F0},
    {1'b1, A_OE_DIS, 32'h0000_00F0},
    {1'b0, A_OE_ST,  32'h0F00_F000},
    {1'b1, A_OE_DIS, 32'h0F00_F000},
    {1'b0, A_OE_ST,  32'h0},
    {1'b1, A_FL_EN,  32'h1234_5678},
    {1'b1, A_FL_DIS, 32'h0204_0608},
    {1'b0, A_FL_ST,  32'h1030_5070},
    {1'b1, A_FL_DIS, 32'hFFFF_FFFF},
    {1'b1, A_DSET,   32'h0000_AAAA},   // R3
    {1'b1, A_DCLR,   32'h0000_000A},
    {1'b0, A_DST,    32'h0000_AAA0},
    {1'b1, A_DCLR,   32'hFFFF_FFFF}
  };

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe, pad_pu, pf_in;
  logic [N-1:0] pfa_out = '1, pfa_oe = '1, pfb_out = '0, pfb_oe = '1;
  logic irq;
  int checks = 0, errors = 0;
  logic [N-1:0] rv;

  always #5 clk = ~clk;

  gpio_port_ctrl #(.N(N), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .pfa_out(pfa_out), .pfa_oe(pfa_oe), .pfb_out(pfb_out), .pfb_oe(pfb_oe),
    .pf_in(pf_in), .irq(irq)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
    for (int i = 0; i < NV; i++) begin
      if (VECS[i][37]) wr(VECS[i][36:32], VECS[i][31:0]);
      else begin
        rd(VECS[i][36:32], rv);
        chk($sformatf("R1/R2/R3 vec %0d", i), rv, VECS[i][31:0]);
      end
    end

    wr(A_OE_EN, 32'h0000_00FF);
    wr(A_DSET, 32'h0000_000F);
    chk("R5 pad_oe", pad_oe, 32'h0000_00FF);
    chk("R5 pad_out", pad_out, 32'h0000_000F);
    wr(A_OD_EN, 32'h0000_0003);
    chk("R6 pad_oe released", pad_oe, 32'h0000_00FC);
    chk("R6 pad_out", pad_out, 32'h0000_000C);
    wr(A_DCLR, 32'h0000_0001);
    chk("R6 pad_oe low", pad_oe, 32'h0000_00FD);
    wr(A_OWN_DIS, 32'h0000_0300);
    wr(A_SEL_B, 32'h0000_0200);
    rd(A_SEL_ST, rv);
    chk("R7 select", rv, 32'h0000_0200);
    chk("R7 pad_out", pad_out & 32'h300, 32'h0000_0100);
    chk("R7 pad_oe", pad_oe & 32'h300, 32'h0000_0300);
    wr(A_PU_DIS, 32'hFFFF_0000);
    chk("R8 pad_pu", pad_pu, 32'h0000_FFFF);

    pad_in = 32'hA5A5_0000;
    idle(4);
    rd(A_PIN, rv);
    chk("R4 pin levels", rv, 32'hA5A5_0000);
    pad_in = '0;
    idle(8);
    rd(A_CHG, rv);
    rd(A_CHG, rv);
    chk("R9 cleared", rv, 32'h0);

    wr(A_IE_EN, 32'h0000_0008);
    wr(A_FL_EN, 32'h0000_0020);
    pad_in[3] = 1;
    idle(3);
    rd(A_CHG, rv);
    chk("R12 old value", rv, 32'h0);
    chk("R10 irq high", {31'b0, irq}, 32'h1);
    rd(A_CHG, rv);
    chk("R12 kept", rv, 32'h0000_0008);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
    pad_in[3] = 0;
    idle(8);
    rd(A_CHG, rv);
    chk("R9 falling", rv, 32'h0000_0008);

    pad_in[5] = 1; @(negedge clk); pad_in[5] = 0;
    idle(8);
    rd(A_CHG, rv);
    chk("R11 filtered pulse", rv, 32'h0);
    pad_in[6] = 1; @(negedge clk); pad_in[6] = 0;
    idle(8);
    chk("R10 masked irq", {31'b0, irq}, 32'h0);
    rd(A_CHG, rv);
    chk("R11/R9 unfiltered masked", rv, 32'h0000_0040);
    pad_in[5] = 1;
    idle(8);
    rd(A_CHG, rv);
    chk("R11 steady level", rv, 32'h0000_0020);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule